// File: doc/BRIEF.md
# I2C EEPROM Slave Protocol Engine

This block is the serial-bus front end of a byte-addressed EEPROM. It runs on a fast system clock and treats the already synchronised SCL and SDA levels as sampled inputs. From them it recognises bus framing, checks the device-select byte against two strap pins, assembles a 17-bit memory address and acknowledges each byte. It drives only an open-drain pull-down enable for SDA.

Toward the storage array the engine issues single-cycle strobes. A load strobe places one byte into the page buffer. A commit pulse starts the internal programming cycle, and an abort pulse discards a rejected write. A read request returns data one clock later. The engine also holds the running address pointer used by plain reads, random-address reads and streaming reads. While the array reports a programming cycle in progress, the engine refuses its own address, so a host can poll for completion. A write-protect pin, sampled at one precise clock edge, can veto a write.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A transaction begins only with a START (SDA falling while SCL is high); bytes clocked while idle draw no acknowledge, and a STOP (SDA rising while SCL is high) returns the engine to idle.
- R2: The device-select byte is, MSB first, the type code 1010, then a bit equal to `pin_sel[1]`, then a bit equal to `pin_sel[0]`, then memory address bit 16, then the direction bit (1 = read); any mismatch leaves the byte unacknowledged and the engine idle.
- R3: The engine pulls SDA low through the 9th clock after an accepted device-select byte, after each of the two address bytes (high byte first) and after each accepted data byte, and it changes `sda_oe` only while SCL is low.
- R4: Each accepted data byte gives one `mem_we` pulse carrying the pointer and the byte; the pointer then advances in its low `PAGE_W` bits only, wrapping inside the page.
- R5: A STOP after a write header with at least one accepted data byte gives one `mem_commit` pulse; a STOP after only the address bytes gives no commit but leaves the pointer at the sent address.
- R6: While `busy_i` is high the device-select byte is not acknowledged, for read and for write.
- R7: `wp_i` is sampled on the SCL falling edge that ends the acknowledge of the low address byte; if it was high, the first data byte is not acknowledged, `mem_abort` pulses once, and nothing is committed.
- R8: In a read the engine shifts data MSB first and changes SDA after SCL falls, releases SDA in the 9th clock, sends the next byte when the host acknowledges, and stays released after a host NoACK.
- R9: After any access the pointer points one past the last byte read or loaded; reads advance across the whole 17-bit space, so address 0x1FFFF is followed by 0x00000.
- R10: A write header with both address bytes, followed by a repeated START and a read header, starts reading at the sent address.
- R11: During and just after reset, `sda_oe`, `mem_we`, `mem_commit`, `mem_abort` and `mem_rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised serial clock level |
| sda_i | input | 1 | Synchronised serial data level |
| pin_sel | input | 2 | Strap levels compared with device-select bits 3:2 |
| wp_i | input | 1 | Write-protect level |
| busy_i | input | 1 | Array programming cycle in progress |
| sda_oe | output | 1 | 1 pulls SDA low |
| mem_we | output | 1 | Load one byte into the page buffer |
| mem_commit | output | 1 | Start programming of loaded bytes |
| mem_abort | output | 1 | Discard loaded bytes |
| mem_rd_req | output | 1 | Read request, data due one clock later |
| mem_addr | output | 17 | Address for load or read |
| mem_wdata | output | 8 | Byte to load |
| mem_rdata | input | 8 | Read data from the array |

## Verification
Write-protect sampling and the release of the address acknowledge both happen on the same SCL falling edge. The bench provokes this from both sides. In one case it raises `wp_i` through the header and drops it just after that edge; in the other it holds the pin low until the edge and raises it just after. The first write must be refused with an abort and no commit, and the second must be committed. In each case the outcome is judged by the data-byte acknowledge, by the strobe counts and by reading the location back.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int ADDR_W = 17;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_RD
  } ee_state_t;
endpackage

// File: rtl/ee_bus_cond.sv
module ee_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/ee_addr_ctr.sv
module ee_addr_ctr import ee_pkg::*; #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_top,
  input  logic              ld_mid,
  input  logic              ld_low,
  input  logic              step_page,
  input  logic              step_lin,
  input  logic [7:0]        din,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] ptr_inc
);
  logic [ADDR_W-1:0] cur;

  assign ptr     = cur;
  assign ptr_inc = cur + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else if (ld_top) begin
      cur[ADDR_W-1] <= din[1];
    end else if (ld_mid) begin
      cur[15:8] <= din;
    end else if (ld_low) begin
      cur[7:0] <= din;
    end else if (step_page) begin
      cur[PAGE_W-1:0] <= cur[PAGE_W-1:0] + 1'b1;
    end else if (step_lin) begin
      cur <= ptr_inc;
    end
  end

  assert_page_stays_R4: assert property (@(posedge clk) disable iff (rst)
    step_page |=> $stable(cur[ADDR_W-1:PAGE_W]));
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave import ee_pkg::*; #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        pin_sel,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              sda_oe,
  output logic              mem_we,
  output logic              mem_commit,
  output logic              mem_abort,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  logic scl_rise, scl_fall, start_c, stop_c;
  ee_state_t st;
  logic [3:0] bitcnt;
  logic ninth, mack, got_data, wp_lat, rd_pend;
  logic [7:0] shreg, obuf, rbuf;
  logic [ADDR_W-1:0] ptr, ptr_inc;
  logic dec, dev_ok, ld_top, ld_mid, ld_low, step_page, step_lin;

  ee_bus_cond u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  ee_addr_ctr #(.PAGE_W(PAGE_W)) u_ctr (
    .clk(clk), .rst(rst), .ld_top(ld_top), .ld_mid(ld_mid), .ld_low(ld_low),
    .step_page(step_page), .step_lin(step_lin), .din(shreg),
    .ptr(ptr), .ptr_inc(ptr_inc)
  );

  // decision point: falling SCL after the 8th bit of a byte
  always_comb begin
    dec       = (st != ST_IDLE) && !start_c && !stop_c && scl_fall && !ninth && (bitcnt == 4'd8);
    dev_ok    = (shreg[7:4] == DEV_TYPE) && (shreg[3:2] == pin_sel) && !busy_i;
    ld_top    = dec && (st == ST_DEV) && dev_ok && !shreg[0];
    ld_mid    = dec && (st == ST_AHI);
    ld_low    = dec && (st == ST_ALO);
    step_page = dec && (st == ST_WR) && !wp_lat;
    step_lin  = dec && (st == ST_RD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  bitcnt <= '0;  ninth <= 1'b0;  mack <= 1'b0;
      got_data <= 1'b0;  wp_lat <= 1'b0;  rd_pend <= 1'b0;
      shreg <= '0;  obuf <= '0;  rbuf <= '0;
      sda_oe <= 1'b0;  mem_we <= 1'b0;  mem_commit <= 1'b0;
      mem_abort <= 1'b0;  mem_rd_req <= 1'b0;
      mem_addr <= '0;  mem_wdata <= '0;
    end else begin
      mem_we     <= 1'b0;
      mem_commit <= 1'b0;
      mem_abort  <= 1'b0;
      mem_rd_req <= 1'b0;
      rd_pend    <= mem_rd_req;
      if (rd_pend) rbuf <= mem_rdata;

      if (start_c) begin
        st <= ST_DEV;  bitcnt <= '0;  ninth <= 1'b0;
        sda_oe <= 1'b0;  got_data <= 1'b0;
      end else if (stop_c) begin
        if (st == ST_WR && got_data) mem_commit <= 1'b1;
        st <= ST_IDLE;  sda_oe <= 1'b0;  got_data <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_i};
            bitcnt <= bitcnt + 4'd1;
          end else begin
            ninth <= 1'b1;
            mack  <= ~sda_i;
          end
        end else if (scl_fall) begin
          if (ninth) begin
            // end of the acknowledge clock
            ninth  <= 1'b0;
            bitcnt <= '0;
            sda_oe <= 1'b0;
            if (st == ST_WR && !got_data) wp_lat <= wp_i;
            if (st == ST_RD) begin
              if (mack) begin
                obuf   <= rbuf;
                sda_oe <= ~rbuf[7];
              end else begin
                st <= ST_IDLE;
              end
            end
          end else if (dec) begin
            unique case (st)
              ST_DEV: begin
                if (dev_ok) begin
                  sda_oe <= 1'b1;
                  if (shreg[0]) begin
                    st <= ST_RD;  mack <= 1'b1;
                    mem_rd_req <= 1'b1;  mem_addr <= ptr;
                  end else begin
                    st <= ST_AHI;
                  end
                end else begin
                  st <= ST_IDLE;
                end
              end
              ST_AHI: begin sda_oe <= 1'b1; st <= ST_ALO; end
              ST_ALO: begin sda_oe <= 1'b1; st <= ST_WR;  end
              ST_WR: begin
                if (wp_lat) begin
                  mem_abort <= 1'b1;
                  st <= ST_IDLE;
                end else begin
                  sda_oe <= 1'b1;  mem_we <= 1'b1;
                  mem_addr <= ptr;  mem_wdata <= shreg;
                  got_data <= 1'b1;
                end
              end
              ST_RD: begin
                sda_oe <= 1'b0;
                mem_rd_req <= 1'b1;
                mem_addr <= ptr_inc;
              end
              default: st <= ST_IDLE;
            endcase
          end else if (st == ST_RD && bitcnt != 4'd0) begin
            sda_oe <= ~obuf[3'd7 - bitcnt[2:0]];
          end
        end
      end
    end
  end

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe);
  assert_drive_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);
  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, mem_commit, mem_abort, mem_rd_req}));
  assert_busy_no_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DEV && busy_i) |=> !$rose(sda_oe));
  assert_wp_blocks_load_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !$past(wp_lat));
endmodule

// File: tb/test_eeprom_i2c_slave.sv
module test_eeprom_i2c_slave;
  import ee_pkg::*;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] pins = 2'b01;
  logic wp = 1'b0, busy = 1'b0;
  logic sda_oe, mem_we, mem_commit, mem_abort, mem_rd_req;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] rdata_m = 8'h00;
  wire sda_bus = sda_m & ~sda_oe;

  eeprom_i2c_slave #(.PAGE_W(PW)) i_eeprom_i2c_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .pin_sel(pins),
    .wp_i(wp), .busy_i(busy), .sda_oe(sda_oe), .mem_we(mem_we),
    .mem_commit(mem_commit), .mem_abort(mem_abort), .mem_rd_req(mem_rd_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(rdata_m)
  );

  int n_chk = 0, n_fail = 0;
  int commits = 0, aborts = 0, busy_cnt = 0;
  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];
  logic [7:0] mem_m [int];
  int pa_q[$];
  logic [7:0] pd_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // array and page-buffer model
  always @(negedge clk) begin
    if (mem_rd_req) rdata_m = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 8'hFF;
    if (mem_we) begin pa_q.push_back(int'(mem_addr)); pd_q.push_back(mem_wdata); end
    if (mem_abort) begin aborts++; pa_q.delete(); pd_q.delete(); end
    if (mem_commit) begin
      commits++;
      foreach (pa_q[i]) mem_m[pa_q[i]] = pd_q[i];
      pa_q.delete(); pd_q.delete();
      busy = 1'b1; busy_cnt = 300;
    end else if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0) busy = 1'b0;
    end
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      if (exp_q.size() > 0) begin e = exp_q.pop_front(); t = tag_q.pop_front(); end
      else begin e = 8'hxx; t = "R8 unexpected byte"; end
      chk(g === e, t, {24'h0, g}, {24'h0, e});
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic m_start();
    sda_m = 1'b1; tick(2); scl_m = 1'b1; tick(3); sda_m = 1'b0; tick(3); scl_m = 1'b0; tick(2);
  endtask
  task automatic m_stop();
    sda_m = 1'b0; tick(2); scl_m = 1'b1; tick(3); sda_m = 1'b1; tick(3);
  endtask
  task automatic bit_out(input logic b);
    sda_m = b; tick(3); scl_m = 1'b1; tick(4); scl_m = 1'b0; tick(1);
  endtask
  task automatic bit_in(output logic b);
    sda_m = 1'b1; tick(3); scl_m = 1'b1; tick(2); b = sda_bus; tick(2); scl_m = 1'b0; tick(1);
  endtask
  task automatic wr_byte(input logic [7:0] d, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(x);
    ack = !x;
  endtask
  task automatic rd_byte(input bit last, output logic [7:0] d);
    logic x;
    for (int i = 7; i >= 0; i--) begin bit_in(x); d[i] = x; end
    bit_out(last);
  endtask
  function automatic logic [7:0] dev(input bit a16, input bit rd);
    return {4'b1010, pins, a16, rd};
  endfunction
  task automatic expect_b(input logic [7:0] d, input string t);
    exp_q.push_back(d); tag_q.push_back(t);
  endtask
  task automatic wr_hdr(input logic [16:0] a, output bit ok);
    bit k1, k2, k3;
    m_start();
    wr_byte(dev(a[16], 1'b0), k1);
    wr_byte(a[15:8], k2);
    wr_byte(a[7:0], k3);
    ok = k1 & k2 & k3;
  endtask
  task automatic rd_seq(input int n, input string t);
    bit k;
    logic [7:0] d;
    m_start();
    wr_byte(dev(1'b0, 1'b1), k);
    chk(k, {t, " read header ack"}, {31'h0, k}, 32'h1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i == n - 1, d);
      got_q.push_back(d);
    end
    tick(2);
    chk(sda_oe == 1'b0, "R8 released after NoACK", {31'h0, sda_oe}, 32'h0);
    m_stop();
  endtask
  task automatic sel_read(input logic [16:0] a, input int n, input string t);
    bit ok;
    wr_hdr(a, ok);
    chk(ok, "R10 selective header ack", {31'h0, ok}, 32'h1);
    rd_seq(n, t);
  endtask
  task automatic wait_ready(); while (busy) tick(1); tick(4); endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ok, ack;
    int c0;
    tick(4);
    chk({sda_oe, mem_we, mem_commit, mem_abort, mem_rd_req} == 5'b0, "R11 reset outputs",
        {27'h0, sda_oe, mem_we, mem_commit, mem_abort, mem_rd_req}, 32'h0);
    rst = 1'b0;
    tick(3);
    chk({sda_oe, mem_we, mem_commit, mem_abort, mem_rd_req} == 5'b0, "R11 after reset",
        {27'h0, sda_oe, mem_we, mem_commit, mem_abort, mem_rd_req}, 32'h0);

    // R2: strap mismatch
    m_start();
    wr_byte({4'b1010, ~pins, 2'b00}, ack);
    chk(!ack, "R2 wrong strap nack", {31'h0, ack}, 32'h0);
    m_stop();

    // R1: no START, byte ignored
    scl_m = 1'b0; tick(2);
    wr_byte(dev(1'b0, 1'b0), ack);
    chk(!ack, "R1 no start nack", {31'h0, ack}, 32'h0);
    m_stop();

    // R3/R4: page write crossing the page end (0x12E..0x121)
    m_start();
    wr_byte(dev(1'b0, 1'b0), ack); chk(ack, "R3 device ack", {31'h0, ack}, 32'h1);
    wr_byte(8'h01, ack);           chk(ack, "R3 high address ack", {31'h0, ack}, 32'h1);
    wr_byte(8'h2E, ack);           chk(ack, "R3 low address ack", {31'h0, ack}, 32'h1);
    for (int i = 0; i < 4; i++) begin
      wr_byte(8'h10 + 8'(i), ack);
      chk(ack, "R3 data ack", {31'h0, ack}, 32'h1);
    end
    c0 = commits;
    m_stop(); tick(2);
    chk(commits == c0 + 1, "R5 commit after data", commits, c0 + 1);

    // R6: busy polling
    m_start(); wr_byte(dev(1'b0, 1'b1), ack);
    chk(!ack, "R6 busy read nack", {31'h0, ack}, 32'h0);
    m_stop();
    m_start(); wr_byte(dev(1'b0, 1'b0), ack);
    chk(!ack, "R6 busy write nack", {31'h0, ack}, 32'h0);
    m_stop();
    wait_ready();
    m_start(); wr_byte(dev(1'b0, 1'b0), ack);
    chk(ack, "R6 ready ack", {31'h0, ack}, 32'h1);
    m_stop();

    // R10 then R9 current address
    expect_b(8'h10, "R10 selective read data");
    sel_read(17'h0012E, 1, "R10");
    expect_b(8'h11, "R9 current address follows");
    rd_seq(1, "R9");
    // R4: page wrap placement, R8 streaming
    expect_b(8'h12, "R4 wrapped byte 0"); expect_b(8'h13, "R4 wrapped byte 1");
    sel_read(17'h00120, 2, "R4");
    expect_b(8'h11, "R8 stream byte 0"); expect_b(8'hFF, "R4 next page untouched");
    sel_read(17'h0012F, 2, "R8");

    // R5: header-only STOP sets the pointer, no commit
    c0 = commits;
    wr_hdr(17'h00121, ok);
    m_stop(); tick(2);
    chk(commits == c0, "R5 no commit header only", commits, c0);
    expect_b(8'h13, "R5 pointer from header");
    rd_seq(1, "R5");

    // R7: WP high at the sampling edge, dropped just after
    c0 = commits;
    wp = 1'b1;
    wr_hdr(17'h00040, ok);
    wp = 1'b0;
    wr_byte(8'h77, ack);
    chk(!ack, "R7 protected data nack", {31'h0, ack}, 32'h0);
    m_stop(); tick(2);
    chk(aborts == 1, "R7 abort pulse", aborts, 1);
    chk(commits == c0, "R7 no commit", commits, c0);
    expect_b(8'hFF, "R7 location unchanged");
    sel_read(17'h00040, 1, "R7");
    // R7: WP low at the sampling edge, raised just after
    wr_hdr(17'h00050, ok);
    wp = 1'b1;
    wr_byte(8'h66, ack);
    chk(ack, "R7 late wp accepted", {31'h0, ack}, 32'h1);
    wp = 1'b0;
    m_stop(); wait_ready();
    expect_b(8'h66, "R7 late wp written");
    sel_read(17'h00050, 1, "R7");

    // R9: wrap from top of memory
    wr_hdr(17'h1FFFF, ok); wr_byte(8'hA5, ack); m_stop(); wait_ready();
    wr_hdr(17'h00000, ok); wr_byte(8'h5A, ack); m_stop(); wait_ready();
    expect_b(8'hA5, "R9 top byte"); expect_b(8'h5A, "R9 wrapped to zero");
    sel_read(17'h1FFFF, 2, "R9");

    tick(20);
    chk(exp_q.size() == 0, "R8 all expected bytes seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule